// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches a single external interrupt request pin on behalf of a processor. Software sets it up through one 8-bit status and control register. The pin is resynchronized into the clock domain. An event is then detected on the active edge, or on the active edge plus the active level. Each event sets a sticky flag. The flag drives an interrupt request when interrupts are enabled; with interrupts disabled, software polls the flag instead.

Software clears the flag by writing 1 to an acknowledge bit, which always reads back as 0. The handler must do this before it returns. While the pin is configured as the interrupt input, its synchronized level can be read from the same register.

A separate wake output is purely combinational, so it can request wake-up while the system clock is stopped.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset every control bit is 0, the flag is 0, the register reads 0x00, and `irq_o` and `wake_o` are 0.
- R2: While pin enable (bit 6) is 0, pin activity never sets the flag, read bit 2 reads 0, and `wake_o` stays 0.
- R3: The pin passes through a two-stage synchronizer. An active edge driven between two clock edges sets the flag at the third rising clock edge after it.
- R4: Polarity (bit 5) equal to 0 makes falling edges and low level active. Polarity equal to 1 makes rising edges and high level active. Edges in the other direction set nothing.
- R5: Mode (bit 4) equal to 0 detects edges only. Mode equal to 1 also counts every clock on which the synchronized pin is at the active level.
- R6: `irq_o` equals the flag ANDed with interrupt enable (bit 3). The flag sets whether or not interrupts are enabled.
- R7: Writing 1 to the acknowledge bit (bit 1) clears the flag at that clock edge, unless an event occurs. Bit 1 always reads 0. A write with bit 1 equal to 0 leaves the flag unchanged.
- R8: An edge event and an acknowledge in the same cycle leave the flag set.
- R9: In edge-and-level mode, an acknowledge while the synchronized pin is still active leaves the flag set.
- R10: Read bit 0 is the flag. Read bit 2 is the synchronized pin level when enabled. Read bits 6..3 return the control bits. Bit 7 reads 0.
- R11: `wake_o` is high exactly when `stop_i` is 1, pin enable is 1, and the raw pin is at the active level. No clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external interrupt pin |
| stop_i | input | 1 | High while system clocks are stopped |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request to the processor |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
The bench builds the block with its default of two synchronizer stages. With that setting the three-cycle latency from pin to flag can be checked exactly, edge by edge.

Random pin toggles, configuration writes and acknowledges reach every combination of polarity, mode and enable. They also make acknowledges land in the same cycle as edge and level events. Directed sequences pin down three cases: the collision of an edge with an acknowledge, acknowledges while the level is held, and the wake path with the clock not advancing.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_W  = 8;
  localparam int B_FLAG = 0;
  localparam int B_ACK  = 1;
  localparam int B_LVL  = 2;
  localparam int B_IEN  = 3;
  localparam int B_MODE = 4;
  localparam int B_POL  = 5;
  localparam int B_PEN  = 6;
  localparam logic SYNC_RST = 1'b1;

  typedef struct packed {
    logic pin_en;
    logic pol;
    logic lvl_mode;
    logic irq_en;
  } cfg_t;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  cfg_t cfg_i,
  output logic evt_o
);
  logic prev_q;
  logic prev_d;
  logic edge_hit;
  logic lvl_hit;

  always_comb begin
    prev_d   = smp_i;
    edge_hit = cfg_i.pol ? (smp_i & ~prev_q) : (~smp_i & prev_q);
    lvl_hit  = cfg_i.lvl_mode & (smp_i == cfg_i.pol);
    evt_o    = cfg_i.pin_en & (edge_hit | lvl_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= SYNC_RST;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/extirq_csr.sv
module extirq_csr
  import extirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             evt_i,
  input  logic             smp_i,
  output cfg_t             cfg_o,
  output logic             flag_o,
  output logic [REG_W-1:0] rd_data_o
);
  cfg_t cfg_q, cfg_d;
  logic flag_q, flag_d;
  logic ack;

  always_comb begin
    cfg_d = cfg_q;
    ack   = wr_en_i & wr_data_i[B_ACK];
    if (wr_en_i) begin
      cfg_d.pin_en   = wr_data_i[B_PEN];
      cfg_d.pol      = wr_data_i[B_POL];
      cfg_d.lvl_mode = wr_data_i[B_MODE];
      cfg_d.irq_en   = wr_data_i[B_IEN];
    end
    if (evt_i)    flag_d = 1'b1;
    else if (ack) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data_o         = '0;
    rd_data_o[B_FLAG] = flag_q;
    rd_data_o[B_LVL]  = cfg_q.pin_en & smp_i;
    rd_data_o[B_IEN]  = cfg_q.irq_en;
    rd_data_o[B_MODE] = cfg_q.lvl_mode;
    rd_data_o[B_POL]  = cfg_q.pol;
    rd_data_o[B_PEN]  = cfg_q.pin_en;
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             stop_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic smp;
  logic evt;
  logic flag;
  cfg_t cfg;

  extirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(smp)
  );

  extirq_detect u_det (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .cfg_i(cfg), .evt_o(evt)
  );

  extirq_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .evt_i(evt), .smp_i(smp), .cfg_o(cfg), .flag_o(flag), .rd_data_o(rd_data_o)
  );

  assign irq_o  = flag & cfg.irq_en;
  assign wake_o = stop_i & cfg.pin_en & (pin_i == cfg.pol);
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk
  import extirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pin_i,
  input logic             stop_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o,
  input logic             wake_o
);
  // R6
  irq_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (rd_data_o[B_FLAG] & rd_data_o[B_IEN]));

  // R7
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data_o[B_ACK]);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[B_ACK] && !rd_data_o[B_PEN]) |=> !rd_data_o[B_FLAG]);

  // R2
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data_o[B_PEN] && !rd_data_o[B_FLAG] && !(wr_en_i && wr_data_i[B_PEN]))
      |=> !rd_data_o[B_FLAG]);

  // R2
  disabled_lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data_o[B_PEN] |-> !rd_data_o[B_LVL]);

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[B_PEN] && rd_data_o[B_MODE] && rd_data_o[B_FLAG] &&
     (rd_data_o[B_LVL] == rd_data_o[B_POL])) |=> rd_data_o[B_FLAG]);

  // R11
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o == (stop_i && rd_data_o[B_PEN] && (pin_i == rd_data_o[B_POL])));
endmodule

bind extirq_ctrl extirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .stop_i(stop_i),
  .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
  .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/sim_extirq_ctrl.sv
`timescale 1ns/1ps
module sim_extirq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1, stop = 1'b0, we = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic irq, wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  extirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .stop_i(stop), .wr_en_i(we),
    .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq), .wake_o(wake)
  );

  // Reference model built from the requirements
  logic ms1, ms2, mprev, mflag, mpe, mpol, mmode, mien;
  always @(posedge clk or negedge rst_n) begin
    logic ev;
    if (!rst_n) begin
      ms1 = 1; ms2 = 1; mprev = 1; mflag = 0;
      mpe = 0; mpol = 0; mmode = 0; mien = 0;
    end else begin
      ev = mpe & ((mpol ? (ms2 & ~mprev) : (~ms2 & mprev)) | (mmode & (ms2 == mpol)));
      if (ev) mflag = 1;
      else if (we && wd[1]) mflag = 0;
      if (we) begin mpe = wd[6]; mpol = wd[5]; mmode = wd[4]; mien = wd[3]; end
      mprev = ms2; ms2 = ms1; ms1 = pin;
    end
  end

  function automatic logic [7:0] exp_rd();
    return {1'b0, mpe, mpol, mmode, mien, mpe & ms2, 1'b0, mflag};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(rd == exp_rd(), "R3 R4 R5 R7 R8 R9 R10 read", rd, exp_rd());
    chk(irq == (mflag & mien), "R6 irq", irq, mflag & mien);
    chk(wake == (stop & mpe & (pin == mpol)), "R11 wake", wake, stop & mpe & (pin == mpol));
  endtask

  task automatic step(input logic p, input logic s, input logic w, input logic [7:0] d);
    @(negedge clk);
    compare();
    pin = p; stop = s; we = w; wd = d;
  endtask

  task automatic idle(input logic p, input int n);
    for (int i = 0; i < n; i++) step(p, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd == 8'h00, "R1 rd", rd, 0);
    chk(!irq && !wake, "R1 irq/wake", {irq, wake}, 0);
    rst_n = 1'b1;
    idle(1, 3);

    // R3 R6 falling edge, edge-only, interrupts on
    step(1, 0, 1, 8'h48);
    idle(1, 4);
    step(0, 0, 0, 8'h00);
    idle(0, 2);
    chk(!rd[0], "R3 flag early", rd[0], 0);
    idle(0, 1);
    chk(rd[0], "R3 flag third edge", rd[0], 1);
    chk(irq, "R6 irq raised", irq, 1);
    chk(!rd[2], "R10 level low", rd[2], 0);

    // R7 acknowledge in edge mode while pin stays low
    step(0, 0, 1, 8'h4A);
    idle(0, 1);
    chk(!rd[0] && !rd[1], "R7 ack clears", rd, 8'h48);
    step(0, 0, 1, 8'h48);
    idle(0, 1);
    chk(!rd[0], "R7 no set without edge", rd[0], 0);

    // R5 R9 level mode with pin held low
    step(0, 0, 1, 8'h58);
    idle(0, 2);
    chk(rd[0], "R5 level sets", rd[0], 1);
    step(0, 0, 1, 8'h5A);
    idle(0, 1);
    chk(rd[0], "R9 ack while active", rd[0], 1);

    // R8 edge and acknowledge in the same cycle
    step(1, 0, 1, 8'h48);
    idle(1, 4);
    step(1, 0, 1, 8'h4A);
    idle(1, 1);
    chk(!rd[0], "R8 cleared before", rd[0], 0);
    step(0, 0, 0, 8'h00);
    idle(0, 1);
    step(0, 0, 1, 8'h4A);
    idle(0, 1);
    chk(rd[0], "R8 event wins", rd[0], 1);

    // R4 rising polarity: falling edge ignored, rising edge sets
    step(0, 0, 1, 8'h6A);
    idle(0, 3);
    chk(!rd[0], "R4 cleared", rd[0], 0);
    idle(1, 4);
    chk(rd[0], "R4 rising sets", rd[0], 1);
    step(1, 0, 1, 8'h62);
    idle(0, 5);
    chk(!rd[0], "R4 falling ignored", rd[0], 0);
    chk(!irq, "R6 poll only", irq, 0);

    // R11 wake with clock edges not involved
    step(0, 1, 0, 8'h00);
    #0.5;
    chk(!wake, "R11 inactive", wake, 0);
    pin = 1'b1; #0.5;
    chk(wake, "R11 active", wake, 1);

    // R2 disabled pin
    step(1, 1, 1, 8'h2A);
    for (int i = 0; i < 12; i++) step(i[0], 1'b1, 1'b0, 8'h00);
    chk(!rd[0] && !rd[2] && !wake, "R2 ignored", {rd[2], rd[0], wake}, 0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic p, s, w;
      logic [7:0] d;
      p = ($urandom % 4 == 0) ? ~pin : pin;
      s = ($urandom % 8 == 0);
      w = ($urandom % 6 == 0);
      d = 8'($urandom);
      step(p, s, w, d);
    end

    @(negedge clk);
    compare();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule